// File: doc/BRIEF.md
# Per-Thread Software Interrupt Dispatch Unit

This block lets any agent on the chip post a software interrupt to any of 64 hardware threads. A single write port takes a dispatch word. The word holds a destination thread number and a vector number. The unit keeps a 64-bit pending bitmap for every thread. It drives one interrupt request line per thread, and that line stays high while the thread has anything pending.

Each thread reads its state back through one shared read port, which has two views. The receive view returns the thread's pending bitmap and changes nothing. The incoming view returns the number of the highest pending vector. It also clears that bit at the clock edge that ends the read, so a handler can drain its queue one vector at a time.

Top module: `swi_unit`

## Requirements
- R1: A dispatch word carries the vector number in bits 5:0 and the destination thread in bits 13:8. All other bits of the word have no effect.
- R2: A dispatch write (`disp_en`=1) sets the named vector bit in the bitmap of the named thread only. That thread's request line is high from the next cycle on.
- R3: With `rd_sel`=0, `rd_data` shows the bitmap of thread `rd_thread` in the same cycle. Such a read, with `rd_en` high or low, leaves every bitmap unchanged.
- R4: With `rd_sel`=1, `rd_data` shows the number of the highest pending vector of `rd_thread`, zero-extended. If `rd_en` is also 1, that bit is cleared at the clock edge.
- R5: An incoming read (`rd_sel`=1) on a thread with an empty bitmap returns 0 and changes nothing.
- R6: `irq[t]` is the OR of thread t's bitmap. It stays high until the last pending bit of that thread is cleared.
- R7: If a dispatch and an incoming read reach the same bitmap in the same cycle, the dispatched bit is kept. The read clears only the bit it returned, even when that is the same bit.
- R8: Dispatches issued on consecutive cycles, one to each of the 64 threads, all land, and each destination ends with exactly its one bit set.
- R9: A synchronous active-high `rst` clears every bitmap and every request line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Dispatch write strobe |
| disp_word | input | 64 | Dispatch word: thread in bits 13:8, vector in bits 5:0 |
| rd_en | input | 1 | Read strobe; with rd_sel=1 it clears the returned bit |
| rd_sel | input | 1 | 0 = receive view (bitmap), 1 = incoming view (vector number) |
| rd_thread | input | 6 | Thread whose registers are read |
| rd_data | output | 64 | Read data for the selected view |
| irq | output | 64 | Per-thread interrupt request lines |

## Verification
A bad bitmap shows at the ports one cycle after the faulty update: on `irq`, and in the receive view of the affected thread. A wrong clear or a wrong priority pick shows on the next incoming read of that thread. It returns a different vector, or it returns a vector that should already have been drained. Collisions and dispatches to every thread in turn are run so that a dropped set or an over-wide clear shows on the request lines within one cycle.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic {
    VIEW_RECEIVE  = 1'b0,
    VIEW_INCOMING = 1'b1
  } rd_view_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int THR_N   = 64,
  parameter int VEC_N   = 64,
  parameter int WORD_W  = 64,
  parameter int THR_LSB = 8
) (
  input  logic              disp_en,
  input  logic [WORD_W-1:0] disp_word,
  output logic [THR_N-1:0]  thr_hit,
  output logic [VEC_N-1:0]  vec_mask
);
  localparam int THR_W = $clog2(THR_N);
  localparam int VEC_W = $clog2(VEC_N);

  logic [THR_W-1:0] thr_field;
  logic [VEC_W-1:0] vec_field;
  logic             word_unused;

  assign thr_field   = disp_word[THR_LSB +: THR_W];
  assign vec_field   = disp_word[VEC_W-1:0];
  assign word_unused = ^{disp_word[WORD_W-1:THR_LSB+THR_W], disp_word[THR_LSB-1:VEC_W]};

  assign thr_hit  = disp_en ? (THR_N'(1) << thr_field) : '0;
  assign vec_mask = disp_en ? (VEC_N'(1) << vec_field) : '0;

  // R1: one thread and one vector are decoded per dispatch, or none at all
  always_comb begin
    a_r1_single_target: assert ($onehot0(thr_hit) && ((thr_hit != '0) == (vec_mask != '0)));
  end
endmodule

// File: rtl/swi_prio_pick.sv
module swi_prio_pick #(
  parameter int VEC_N = 64
) (
  input  logic [VEC_N-1:0]         req,
  output logic                     any,
  output logic [$clog2(VEC_N)-1:0] idx,
  output logic [VEC_N-1:0]         pick_mask
);
  localparam int VEC_W = $clog2(VEC_N);

  function automatic logic [VEC_W-1:0] top_index(input logic [VEC_N-1:0] r);
    logic [VEC_W-1:0] best;
    best = '0;
    for (int i = 0; i < VEC_N; i++) begin
      if (r[i]) best = VEC_W'(i);
    end
    return best;
  endfunction

  assign any       = |req;
  assign idx       = top_index(req);
  assign pick_mask = any ? (VEC_N'(1) << idx) : '0;

  // R4: the pick is pending and no higher vector is pending
  always_comb begin
    if (any) begin
      a_r4_pick_is_top: assert ((req >> idx) == VEC_N'(1));
    end
  end
endmodule

// File: rtl/swi_thread_bank.sv
module swi_thread_bank #(
  parameter int VEC_N = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_N-1:0] set_mask,
  input  logic [VEC_N-1:0] clr_mask,
  output logic [VEC_N-1:0] bitmap,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) bitmap <= '0;
    else     bitmap <= (bitmap & ~clr_mask) | set_mask;
  end

  assign irq = |bitmap;

  // R2: a dispatched bit is present on the next cycle
  a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> ((bitmap & $past(set_mask)) == $past(set_mask)));

  // R6: the request holds while nothing is cleared
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && clr_mask == '0) |=> irq);

  // R7: a read clears at most one bit
  a_r7_single_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_mask));
endmodule

// File: rtl/swi_unit.sv
module swi_unit #(
  parameter int NUM_THR = 64,
  parameter int NUM_VEC = 64,
  parameter int WORD_W  = 64,
  parameter int DATA_W  = 64,
  parameter int THR_LSB = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       disp_en,
  input  logic [WORD_W-1:0]          disp_word,
  input  logic                       rd_en,
  input  logic                       rd_sel,
  input  logic [$clog2(NUM_THR)-1:0] rd_thread,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_THR-1:0]         irq
);
  import swi_pkg::*;
  localparam int VEC_W = $clog2(NUM_VEC);

  logic [NUM_THR-1:0] thr_hit;
  logic [NUM_VEC-1:0] vec_mask;
  logic [NUM_VEC-1:0] bm_all [NUM_THR];
  logic [NUM_VEC-1:0] sel_bm;
  logic               pick_any;
  logic [VEC_W-1:0]   pick_idx;
  logic [NUM_VEC-1:0] pick_mask;
  logic               pop_fire;
  logic               disp_same_bit;
  rd_view_e           view;

  swi_decode #(.THR_N(NUM_THR), .VEC_N(NUM_VEC), .WORD_W(WORD_W), .THR_LSB(THR_LSB)) u_dec (
    .disp_en(disp_en), .disp_word(disp_word), .thr_hit(thr_hit), .vec_mask(vec_mask));

  assign view   = rd_view_e'(rd_sel);
  assign sel_bm = bm_all[rd_thread];

  swi_prio_pick #(.VEC_N(NUM_VEC)) u_pick (
    .req(sel_bm), .any(pick_any), .idx(pick_idx), .pick_mask(pick_mask));

  assign pop_fire      = rd_en && (view == VIEW_INCOMING) && pick_any;
  assign disp_same_bit = thr_hit[rd_thread] && ((vec_mask & pick_mask) != '0);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [NUM_VEC-1:0] clr_t;
    assign clr_t = (pop_fire && rd_thread == t) ? pick_mask : '0;
    swi_thread_bank #(.VEC_N(NUM_VEC)) u_bank (
      .clk(clk), .rst(rst),
      .set_mask(thr_hit[t] ? vec_mask : '0),
      .clr_mask(clr_t),
      .bitmap(bm_all[t]),
      .irq(irq[t]));
  end

  assign rd_data = (view == VIEW_INCOMING) ? DATA_W'(pick_idx) : DATA_W'(sel_bm);

  // R4: the returned vector is gone on the next cycle unless re-dispatched
  a_r4_pop_clears: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && !disp_same_bit) |=> ((bm_all[$past(rd_thread)] & $past(pick_mask)) == '0));

  // R7: a colliding dispatch of the returned vector survives
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && disp_same_bit) |=> ((bm_all[$past(rd_thread)] & $past(pick_mask)) != '0));

  // R5: an incoming read of an empty thread returns zero
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (view == VIEW_INCOMING && !pick_any) |-> (rd_data == '0));

  // R9: after reset no request line is high
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (irq == '0));
endmodule

// File: tb/swi_unit_tb_top.sv
`timescale 1ns/1ps
module swi_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_en = 1'b0;
  logic [63:0] disp_word = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [5:0]  rd_thread = '0;
  logic [63:0] rd_data;
  logic [63:0] irq;

  always #2.5 clk = ~clk;

  swi_unit dut_i (.clk(clk), .rst(rst), .disp_en(disp_en), .disp_word(disp_word),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_thread(rd_thread), .rd_data(rd_data), .irq(irq));

  logic [63:0] model_bm [64];
  logic [63:0] exp_q [$];
  int          kind_q [$];
  string       tag_q [$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  task automatic push(input int kind, input logic [63:0] e, input string tag);
    exp_q.push_back(e); kind_q.push_back(kind); tag_q.push_back(tag);
  endtask

  // monitor: compares queued expectations after the driver has settled inputs
  initial begin
    forever begin
      @(negedge clk); #1;
      while (exp_q.size() > 0) begin
        logic [63:0] e, act;
        int k;
        string tg;
        e = exp_q.pop_front(); k = kind_q.pop_front(); tg = tag_q.pop_front();
        act = (k == 1) ? irq : rd_data;
        n_cmp++;
        if (act !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", tg, act, e);
        end
      end
    end
  end

  function automatic logic [63:0] model_irq();
    logic [63:0] r;
    for (int t = 0; t < 64; t++) r[t] = (model_bm[t] != 64'd0);
    return r;
  endfunction

  function automatic logic [63:0] model_top(input int thr);
    for (int v = 63; v >= 0; v--) if (model_bm[thr][v]) return 64'(v);
    return 64'd0;
  endfunction

  // R1: thread in 13:8, vector in 5:0, junk elsewhere
  function automatic logic [63:0] mkword(input int thr, input int vec, input logic [63:0] junk);
    return (junk & ~64'h3F3F) | (64'(thr) << 8) | 64'(vec);
  endfunction

  task automatic op(input bit d, input logic [63:0] w, input bit re, input bit rs,
                    input int thr, input bit chk, input string tag);
    int top;
    @(negedge clk);
    disp_en = d; disp_word = w; rd_en = re; rd_sel = rs; rd_thread = 6'(thr);
    push(1, model_irq(), {tag, " irq"});
    if (chk) push(0, rs ? model_top(thr) : model_bm[thr], tag);
    top = int'(model_top(thr));
    @(posedge clk);
    if (re && rs && model_bm[thr] != 64'd0) model_bm[thr][top] = 1'b0;
    if (d) model_bm[int'(w[13:8])][w[5:0]] = 1'b1;
  endtask

  task automatic idle_chk(input int thr, input bit rs, input string tag);
    op(0, 64'd0, 0, rs, thr, 1, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 64; t++) model_bm[t] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle_chk(5, 0, "R9 reset receive");

    // R8: back-to-back dispatch, thread t gets vector t
    for (int t = 0; t < 64; t++) op(1, mkword(t, t, 64'd0), 0, 0, 0, 0, "R8 burst");
    idle_chk(0, 0, "R8 thread0 receive");
    idle_chk(63, 0, "R8 thread63 receive");
    idle_chk(17, 1, "R2 thread17 incoming");
    // drain every thread through the incoming view
    for (int t = 0; t < 64; t++) op(0, 64'd0, 1, 1, t, 1, "R4 drain pop");
    idle_chk(40, 0, "R4 drained receive");
    idle_chk(40, 1, "R5 drained incoming");
    op(0, 64'd0, 1, 1, 40, 1, "R5 empty pop");
    idle_chk(40, 0, "R5 empty pop no change");

    // R1: junk bits ignored
    op(1, mkword(3, 5, 64'hFFFF_FFFF_FFFF_FFFF), 0, 0, 3, 0, "R1 junk dispatch");
    idle_chk(3, 0, "R1 junk receive");
    op(1, mkword(3, 40, 64'hA5A5_0000_0000_00C0), 0, 0, 3, 0, "R1 junk dispatch");
    op(1, mkword(3, 17, 64'd0), 0, 0, 3, 0, "R2 dispatch");
    // R3: receive reads twice, no side effect
    op(0, 64'd0, 1, 0, 3, 1, "R3 receive read");
    op(0, 64'd0, 1, 0, 3, 1, "R3 receive reread");
    // R4: priority order 40, 17, 5; R6 irq holds until last
    op(0, 64'd0, 1, 1, 3, 1, "R4 pop top");
    op(0, 64'd0, 1, 1, 3, 1, "R4 pop next");
    idle_chk(3, 0, "R6 one left");
    op(0, 64'd0, 1, 1, 3, 1, "R4 pop last");
    idle_chk(3, 1, "R6 empty incoming");

    // R7: collisions on thread 9
    op(1, mkword(9, 10, 64'd0), 0, 0, 9, 0, "R7 setup");
    op(1, mkword(9, 10, 64'd0), 1, 1, 9, 1, "R7 same bit pop");
    idle_chk(9, 0, "R7 same bit kept");
    op(1, mkword(9, 20, 64'd0), 1, 1, 9, 1, "R7 other bit pop");
    idle_chk(9, 0, "R7 other bit kept");
    op(1, mkword(9, 63, 64'd0), 1, 1, 9, 1, "R7 higher set pop");
    idle_chk(9, 0, "R7 higher kept");

    // R9: reset mid-run
    op(1, mkword(50, 2, 64'd0), 0, 0, 50, 0, "R9 pre-reset");
    @(negedge clk); rst = 1'b1; disp_en = 0; rd_en = 0;
    @(posedge clk);
    for (int t = 0; t < 64; t++) model_bm[t] = 64'd0;
    @(negedge clk); rst = 1'b0;
    idle_chk(50, 0, "R9 after reset");
    idle_chk(9, 0, "R9 after reset t9");

    @(negedge clk); #2;
    done = 1;
    summary();
    $finish;
  end
endmodule